// File: doc/BRIEF.md
# Vectored Interrupt Routing Multiplexer

This block gathers a bank of level-sensitive interrupt sources and steers them onto a small set of output request lines, one per channel. Each channel owns a mask that picks which sources may reach it. A channel raises its request to the upstream controller while any source that it selects is active.

Each channel also has a vector register that names the source the handler should serve. When more than one selected source is active, the lowest index wins. Sources are not captured or held. The request and the vector follow the live inputs, registered once. If the source that caused an interrupt has already dropped by the time software reads the vector, the vector reads zero, and the handler can discard the interrupt as spurious.

Software works through a flat register bus with one access per cycle. Writes take effect on the clock edge and reads return data in the same cycle. Each channel's register group sits in its own 64-byte window. A control register in that window has a self-clearing bit that returns the channel's mask, request and vector to their reset state.

Top module: `irq_router`

## Requirements
- R1: After global reset every channel mask reads 0, every request output is low and every vector register reads 0.
- R2: The mask of channel c is written and read at byte address c*0x40 + 0x10. Bit n of the mask selects source n for that channel.
- R3: A channel's request output is high exactly one clock after a cycle in which at least one source is both active and selected by that channel's mask.
- R4: When the channel's request is high, its vector register at c*0x40 + 0x04 reads (n + 48) * 4, where n is the lowest-numbered source that was active and selected in the same sampled cycle. The vector's low two bits are always 0.
- R5: A channel's vector reads 0 whenever no selected source was active in the sampled cycle, even if unselected sources are active.
- R6: Sources are not latched. One clock after a selected source drops with no other selected source active, the request returns low and the vector returns to 0.
- R7: Writing a 1 to bit 0 of the control register at c*0x40 + 0x00 clears channel c's mask, request and vector at that clock edge. The control register always reads 0, and no other channel is affected.
- R8: Writes to a vector register are ignored: the vector and the mask of that channel keep their values.
- R9: Channels are independent. Writing one channel's mask does not change any other channel's mask, request or vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Byte address: bits [8:6] pick the channel, bits [5:0] pick the register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| src_lines | input | 32 | Live level-sensitive interrupt sources |
| chan_req | output | 8 | Registered per-channel interrupt request |

## Verification
A wrong mask shows up in two places. The mask readback differs at once, and one clock later the request and vector disagree with the sources applied. A fault in the priority encoder shows only in the vector, as the wrong index when several sources are active together, one clock after they are applied. A reset bit that does not clear, or that clears the wrong channel, is seen at the next read of any channel's mask, request or vector.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int OFF_W = 6;

  typedef enum logic [OFF_W-1:0] {
    REG_CTRL = 6'h00,
    REG_VEC  = 6'h04,
    REG_MASK = 6'h10
  } reg_off_e;

  // Vector code for a winning source index.
  function automatic logic [31:0] vec_code(input int unsigned idx, input int unsigned base);
    logic [31:0] v;
    v = 32'(idx + base);
    return v << 2;
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_router_pkg::*;
#(
  parameter int N_CHAN = 8,
  parameter int DW     = 32,
  localparam int CH_W  = $clog2(N_CHAN),
  localparam int AW    = CH_W + OFF_W
) (
  input  logic [AW-1:0]              addr,
  input  logic                       we,
  input  logic                       wbit0,
  input  logic [N_CHAN-1:0][DW-1:0]  mask_q,
  input  logic [N_CHAN-1:0][DW-1:0]  vec_q,
  output logic [N_CHAN-1:0]          mask_wr,
  output logic [N_CHAN-1:0]          chan_clr,
  output logic [DW-1:0]              rdata
);

  logic [CH_W-1:0]  sel;
  logic [OFF_W-1:0] off;

  assign sel = addr[AW-1:OFF_W];
  assign off = addr[OFF_W-1:0];

  for (genvar c = 0; c < N_CHAN; c++) begin : g_dec
    logic hit;
    assign hit         = we && (sel == CH_W'(c));
    assign mask_wr[c]  = hit && (off == REG_MASK);
    assign chan_clr[c] = hit && (off == REG_CTRL) && wbit0;
  end

  always_comb begin
    case (off)
      REG_VEC:  rdata = vec_q[sel];
      REG_MASK: rdata = mask_q[sel];
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_chan_mask.sv
module irq_chan_mask #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_q <= '0;
    else if (clr) mask_q <= '0;
    else if (wr)  mask_q <= wdata;
  end

endmodule

// File: rtl/irq_chan_eval.sv
module irq_chan_eval
  import irq_router_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int VEC_BASE = 48,
  localparam int IDX_W   = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] mask,
  output logic             req_q,
  output logic [31:0]      vec_q
);

  logic [N_SRC-1:0] live;
  logic [IDX_W-1:0] win_idx;
  logic             any_live;

  assign live     = src & mask;
  assign any_live = |live;

  // Lowest index wins: scan downward so the last hit is the lowest.
  always_comb begin
    win_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (live[i]) win_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else if (clr) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= any_live;
      vec_q <= any_live ? vec_code(int'(win_idx), VEC_BASE) : '0;
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int N_CHAN   = 8,
  parameter int VEC_BASE = 48,
  localparam int DW      = 32,
  localparam int AW      = $clog2(N_CHAN) + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N_SRC-1:0]  src_lines,
  output logic [N_CHAN-1:0] chan_req
);

  logic [N_CHAN-1:0][DW-1:0] en_mask;
  logic [N_CHAN-1:0][DW-1:0] vec_q;
  logic [N_CHAN-1:0]         mask_wr;
  logic [N_CHAN-1:0]         chan_clr;

  irq_bus_decode #(.N_CHAN(N_CHAN), .DW(DW)) u_dec (
    .addr     (bus_addr),
    .we       (bus_we),
    .wbit0    (bus_wdata[0]),
    .mask_q   (en_mask),
    .vec_q    (vec_q),
    .mask_wr  (mask_wr),
    .chan_clr (chan_clr),
    .rdata    (bus_rdata)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    logic [N_SRC-1:0] sel_mask;

    irq_chan_mask #(.DW(DW)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (mask_wr[c]),
      .clr    (chan_clr[c]),
      .wdata  (bus_wdata),
      .mask_q (en_mask[c])
    );

    if (N_SRC >= DW) begin : g_wide
      assign sel_mask = N_SRC'(en_mask[c]);
    end else begin : g_narrow
      assign sel_mask = en_mask[c][N_SRC-1:0];
    end

    irq_chan_eval #(.N_SRC(N_SRC), .VEC_BASE(VEC_BASE)) u_eval (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (chan_clr[c]),
      .src   (src_lines),
      .mask  (sel_mask),
      .req_q (chan_req[c]),
      .vec_q (vec_q[c])
    );
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_SRC    = 32,
  parameter int N_CHAN   = 8,
  parameter int VEC_BASE = 48
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_SRC-1:0]         src_lines,
  input logic [N_CHAN-1:0]        chan_req,
  input logic [N_CHAN-1:0][31:0]  en_mask,
  input logic [N_CHAN-1:0][31:0]  vec_q,
  input logic [N_CHAN-1:0]        chan_clr
);

  localparam logic [31:0] VEC_LO = 32'(VEC_BASE) << 2;
  localparam logic [31:0] VEC_HI = 32'(VEC_BASE + N_SRC - 1) << 2;

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (chan_req == '0));

  for (genvar c = 0; c < N_CHAN; c++) begin : g_p
    p_req_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(chan_clr[c])) |->
        (chan_req[c] == |($past(src_lines) & N_SRC'($past(en_mask[c])))));

    p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      chan_req[c] |-> (vec_q[c] >= VEC_LO && vec_q[c] <= VEC_HI && vec_q[c][1:0] == 2'b00));

    p_vec_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_req[c] |-> (vec_q[c] == '0));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chan_clr[c] |=> (en_mask[c] == '0 && !chan_req[c] && vec_q[c] == '0));
  end

endmodule

bind irq_router irq_router_chk #(
  .N_SRC(N_SRC), .N_CHAN(N_CHAN), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_lines (src_lines),
  .chan_req  (chan_req),
  .en_mask   (en_mask),
  .vec_q     (vec_q),
  .chan_clr  (chan_clr)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] src = '0;
  logic [7:0]  req;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .src_lines(src), .chan_req(req)
  );

  // chan, mask, sources, expected vector ((n+48)*4, 0 when none), expected request
  localparam int NT = 6;
  localparam int          T_CH  [NT] = '{0, 7, 2, 5, 3, 6};
  localparam logic [31:0] T_MSK [NT] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0C00,
                                         32'h0000_0004, 32'h0000_0000, 32'hFFFF_0000};
  localparam logic [31:0] T_SRC [NT] = '{32'h0000_0001, 32'h8000_0000, 32'h0000_0F00,
                                         32'h0000_0005, 32'h0000_FFFF, 32'h0001_0000};
  localparam logic [31:0] T_VEC [NT] = '{32'h0C0, 32'h13C, 32'h0E8, 32'h0C8, 32'h000, 32'h100};
  localparam logic        T_REQ [NT] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  function automatic logic [8:0] ra(int c, int off);
    return 9'(c * 64 + off);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", 32'(req), 32'h0);
    for (int c = 0; c < 8; c++) begin
      rd(ra(c, 16), d); chk("R1 mask", d, 32'h0);
      rd(ra(c, 4), d);  chk("R1 vec", d, 32'h0);
    end

    // Table walk: R2 R3 R4 R5 R9
    for (int t = 0; t < NT; t++) begin
      wr(ra(T_CH[t], 16), T_MSK[t]);
      src = T_SRC[t];
      @(negedge clk);
      chk("R3 req", 32'(req[T_CH[t]]), 32'(T_REQ[t]));
      chk("R9 other req", 32'(req & ~(8'h1 << T_CH[t])), 32'h0);
      rd(ra(T_CH[t], 4), d);  chk("R4/R5 vec", d, T_VEC[t]);
      rd(ra(T_CH[t], 16), d); chk("R2 mask", d, T_MSK[t]);
      src = '0;
      wr(ra(T_CH[t], 16), 32'h0);
    end

    // R6 not latched
    wr(ra(1, 16), 32'h0000_0100);
    src = 32'h0000_0100;
    @(negedge clk);
    chk("R6 req up", 32'(req[1]), 32'h1);
    src = '0;
    @(negedge clk);
    chk("R6 req down", 32'(req[1]), 32'h0);
    rd(ra(1, 4), d); chk("R6 vec zero", d, 32'h0);
    wr(ra(1, 16), 32'h0);

    // R7 channel clear, R9 neighbour untouched
    wr(ra(2, 16), 32'h0000_0002);
    wr(ra(3, 16), 32'h0000_0002);
    src = 32'h0000_0002;
    @(negedge clk);
    chk("R7 pre req", 32'(req[3:2]), 32'h3);
    wr(ra(2, 0), 32'h1);
    chk("R7 req cleared", 32'(req[2]), 32'h0);
    rd(ra(2, 16), d); chk("R7 mask cleared", d, 32'h0);
    rd(ra(2, 4), d);  chk("R7 vec cleared", d, 32'h0);
    rd(ra(2, 0), d);  chk("R7 ctrl reads 0", d, 32'h0);
    chk("R9 neighbour req", 32'(req[3]), 32'h1);
    rd(ra(3, 16), d); chk("R9 neighbour mask", d, 32'h2);

    // R8 vector write ignored
    wr(ra(3, 4), 32'hFFFF_FFFF);
    rd(ra(3, 4), d);  chk("R8 vec kept", d, 32'h0C4);
    rd(ra(3, 16), d); chk("R8 mask kept", d, 32'h2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule